// File: doc/BRIEF.md
# Security State Monitor

This block keeps track of how far a device may trust itself and therefore which keys it may use. After power-on reset it leaves its initial state and waits in a checking state. There, boot software either finds the device unfit, which happens on an external boot source or a pending hardware violation, or it promotes the device to trusted and later to secure by writing command bits. Hardware violations come from a filtered active-low tamper pin, a fuse-read error, a master-key parity error, a scan entry or exit event and a power-glitch detector. Each violation is latched until reset. Software can declare a failure of its own.

From the trusted or secure states, a violation or a software failure request drops the device into a soft-fail state. If software armed the hard-fail option beforehand, the device goes to a hard-fail state that also asks the system for a reset. Both fail states, and the non-secure state, are left only through power-on reset. Each state drives a fixed key permission, a key-clear command, an interrupt and the reset request to the key store and the reset controller that sit next to this block.

Top module: `sec_state_mon`

## Requirements
- R1: While reset is applied and on the first two clock edges after it is released, the state output is Init (code 0), key_sel is none (code 0), and key_clr, irq and reset_req are low. On the third edge after release the state becomes Check (code 1).
- R2: In Check, a high boot_ext moves the state to Non-Secure (code 2) on the next edge, where key_sel is the test key (code 1) and key_clr, irq and reset_req are low.
- R3: In Check with no violation pending, a command write with bit 0 (trust) set moves the state to Trusted (code 3) on that edge, and key_sel becomes device keys (code 2).
- R4: In Trusted, a command write with bit 1 (secure) set and bit 2 clear moves the state to Secure (code 4) with device keys. A secure write in Check has no effect on the state.
- R5: A pending hardware violation in Check sends the state to Non-Secure, even when a trust write arrives on the same edge.
- R6: In Trusted or Secure, a pending violation or a write with bit 2 (soft fail) set moves the state to Soft Fail (code 5) while hard fail is not armed. There, key_sel is none, key_clr and irq are high, and reset_req is low. Soft fail has priority over secure in the same write.
- R7: Command bit 3 arms hard fail. It can only be set, stays set until reset, and applies from the edge after the write, in any state. With hard fail armed, the transitions of R6 lead to Hard Fail (code 6), which has the outputs of Soft Fail plus a high reset_req.
- R8: tamper_n passes through two synchronizer flops and counts as a violation only when two consecutive synchronized samples are low. A low level held from just before edge k moves Trusted to a fail state on edge k+4. A low pulse covering a single edge has no effect.
- R9: Each of fuse_err, mk_parity_err, scan_evt and glitch_evt is a violation source. Any of them high on one edge latches a pending violation, which moves Trusted or Secure to a fail state on the next edge.
- R10: Non-Secure, Soft Fail and Hard Fail ignore every further command write and violation until reset. Their outputs, including reset_req, stay constant.
- R11: A soft-fail write in Check has no effect on the state, and a later trust write still reaches Trusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| boot_ext | input | 1 | Device booted from an external source |
| tamper_n | input | 1 | Tamper pin, low means tampered, asynchronous |
| fuse_err | input | 1 | Fuse read or fuse parity failure |
| mk_parity_err | input | 1 | Master key parity failure |
| scan_evt | input | 1 | Scan entry or exit detected |
| glitch_evt | input | 1 | Power glitch detected |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 4 | Command bits: 0 trust, 1 secure, 2 soft fail, 3 arm hard fail |
| state | output | 3 | Current security state code |
| key_sel | output | 2 | Key permission: 0 none, 1 test key, 2 device keys |
| key_clr | output | 1 | Clear master key and key-encryption key |
| irq | output | 1 | Failure interrupt |
| reset_req | output | 1 | System reset request |

## Verification
All sixteen command values are written once in Check and once in Trusted. This separates the bits the current state honours from those it ignores, shows soft fail winning over secure, and shows that the arm bit takes effect only after its own write. Each of the five violation sources is then raised alone, from both Trusted and Secure, with hard fail armed and unarmed. The edge on which the state moves is checked, which shows the extra latency of the tamper filter against the direct sources. Single-edge tamper pulses, boot_ext, a violation that coincides with a trust write, and writes aimed at terminal states cover the filtering, the priority and the holding of states.

// File: rtl/sec_state_pkg.sv
package sec_state_pkg;

  typedef enum logic [2:0] {
    ST_INIT     = 3'd0,
    ST_CHECK    = 3'd1,
    ST_NONSEC   = 3'd2,
    ST_TRUSTED  = 3'd3,
    ST_SECURE   = 3'd4,
    ST_SOFTFAIL = 3'd5,
    ST_HARDFAIL = 3'd6
  } sec_state_e;

  typedef enum logic [1:0] {
    KEY_NONE   = 2'd0,
    KEY_TEST   = 2'd1,
    KEY_DEVICE = 2'd2
  } key_sel_e;

  localparam int CMD_W       = 4;
  localparam int CMD_TRUST   = 0;
  localparam int CMD_SECURE  = 1;
  localparam int CMD_SOFT    = 2;
  localparam int CMD_HF_ARM  = 3;

endpackage

// File: rtl/ssm_tamper_filter.sv
module ssm_tamper_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tamper_n,
  output logic tamper_hit
);

  localparam int HIST_W = QUAL_SAMPLES - 1;

  logic [SYNC_STAGES-1:0]  sync_q;
  logic [HIST_W-1:0]       hist_q;
  logic [QUAL_SAMPLES-1:0] window;

  // Synchronizer chain; idle level is "not tampered".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tamper_n};
    end
  end

  assign window = {hist_q, sync_q[SYNC_STAGES-1]};

  // History of earlier synchronized samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
    end else begin
      hist_q <= window[QUAL_SAMPLES-2:0];
    end
  end

  assign tamper_hit = ~|window;

endmodule

// File: rtl/ssm_viol_agg.sv
module ssm_viol_agg #(
  parameter int N_SRC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  output logic             pend
);

  logic pend_q;
  logic any_src;

  assign any_src = |src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (any_src) begin
      pend_q <= 1'b1;
    end
  end

  assign pend = pend_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> pend);

  assert_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> pend);

endmodule

// File: rtl/ssm_fsm.sv
module ssm_fsm
  import sec_state_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_ext,
  input  logic             hw_pend,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  output sec_state_e       state
);

  sec_state_e state_q, state_d;
  logic       hf_en_q;
  logic       wr_trust, wr_secure, wr_soft, wr_arm;
  logic       fail_req;
  sec_state_e fail_target;

  assign wr_trust  = cmd_wr & cmd_data[CMD_TRUST];
  assign wr_secure = cmd_wr & cmd_data[CMD_SECURE];
  assign wr_soft   = cmd_wr & cmd_data[CMD_SOFT];
  assign wr_arm    = cmd_wr & cmd_data[CMD_HF_ARM];

  assign fail_req    = hw_pend | wr_soft;
  assign fail_target = hf_en_q ? ST_HARDFAIL : ST_SOFTFAIL;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:    state_d = ST_CHECK;
      ST_CHECK: begin
        if (boot_ext || hw_pend) state_d = ST_NONSEC;
        else if (wr_trust)       state_d = ST_TRUSTED;
      end
      ST_TRUSTED: begin
        if (fail_req)       state_d = fail_target;
        else if (wr_secure) state_d = ST_SECURE;
      end
      ST_SECURE: begin
        if (fail_req) state_d = fail_target;
      end
      default:    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
    end else begin
      state_q <= state_d;
    end
  end

  // Arm bit: set-only, cleared by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_en_q <= 1'b0;
    end else if (wr_arm) begin
      hf_en_q <= 1'b1;
    end
  end

  assign state = state_q;

  assert_fail_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SOFTFAIL || state_q == ST_HARDFAIL || state_q == ST_NONSEC)
      |=> $stable(state_q));

  assert_trusted_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRUSTED && $past(state_q) != ST_TRUSTED)
      |-> $past(state_q) == ST_CHECK);

  assert_pend_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && hw_pend) |=> state_q == ST_NONSEC);

  assert_hard_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HARDFAIL && $past(state_q) != ST_HARDFAIL) |-> $past(hf_en_q));

  assert_secure_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SECURE && $past(state_q) != ST_SECURE)
      |-> $past(state_q) == ST_TRUSTED);

endmodule

// File: rtl/ssm_key_policy.sv
module ssm_key_policy
  import sec_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sec_state_e state,
  output key_sel_e   key_sel,
  output logic       key_clr,
  output logic       irq,
  output logic       reset_req
);

  always_comb begin
    key_sel   = KEY_NONE;
    key_clr   = 1'b0;
    irq       = 1'b0;
    reset_req = 1'b0;
    unique case (state)
      ST_NONSEC:               key_sel = KEY_TEST;
      ST_TRUSTED, ST_SECURE:   key_sel = KEY_DEVICE;
      ST_SOFTFAIL: begin
        key_clr = 1'b1;
        irq     = 1'b1;
      end
      ST_HARDFAIL: begin
        key_clr   = 1'b1;
        irq       = 1'b1;
        reset_req = 1'b1;
      end
      default:                 key_sel = KEY_NONE;
    endcase
  end

  assert_clr_no_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |-> key_sel == KEY_NONE);

  assert_rstreq_superset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (irq && key_clr));

  assert_rstreq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

endmodule

// File: rtl/sec_state_mon.sv
module sec_state_mon
  import sec_state_pkg::*;
#(
  parameter int RST_SYNC     = 2,
  parameter int TAMP_SYNC    = 2,
  parameter int TAMP_QUAL    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_ext,
  input  logic             tamper_n,
  input  logic             fuse_err,
  input  logic             mk_parity_err,
  input  logic             scan_evt,
  input  logic             glitch_evt,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  output logic [2:0]       state,
  output logic [1:0]       key_sel,
  output logic             key_clr,
  output logic             irq,
  output logic             reset_req
);

  localparam int N_SRC = 5;

  logic [RST_SYNC-1:0] rst_sync_q;
  logic                rst_int_n;
  logic                tamper_hit;
  logic [N_SRC-1:0]    hw_src;
  logic                hw_pend;
  sec_state_e          cur_state;
  key_sel_e            key_sel_e_w;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_SYNC-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[RST_SYNC-1];

  ssm_tamper_filter #(
    .SYNC_STAGES  (TAMP_SYNC),
    .QUAL_SAMPLES (TAMP_QUAL)
  ) u_tamper (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tamper_n   (tamper_n),
    .tamper_hit (tamper_hit)
  );

  assign hw_src = {glitch_evt, scan_evt, mk_parity_err, fuse_err, tamper_hit};

  ssm_viol_agg #(.N_SRC(N_SRC)) u_agg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .src   (hw_src),
    .pend  (hw_pend)
  );

  ssm_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .boot_ext (boot_ext),
    .hw_pend  (hw_pend),
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .state    (cur_state)
  );

  ssm_key_policy u_keys (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state     (cur_state),
    .key_sel   (key_sel_e_w),
    .key_clr   (key_clr),
    .irq       (irq),
    .reset_req (reset_req)
  );

  assign state   = cur_state;
  assign key_sel = key_sel_e_w;

endmodule

// File: tb/sec_state_mon_test.sv
`timescale 1ns/1ps
module sec_state_mon_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       boot_ext, tamper_n, fuse_err, mk_parity_err, scan_evt, glitch_evt;
  logic       cmd_wr;
  logic [3:0] cmd_data;
  logic [2:0] state;
  logic [1:0] key_sel;
  logic       key_clr, irq, reset_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam int S_INIT = 0, S_CHECK = 1, S_NONSEC = 2, S_TRUSTED = 3,
                 S_SECURE = 4, S_SOFT = 5, S_HARD = 6;

  always #2.5 clk = ~clk;

  sec_state_mon uut (
    .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .tamper_n(tamper_n),
    .fuse_err(fuse_err), .mk_parity_err(mk_parity_err), .scan_evt(scan_evt),
    .glitch_evt(glitch_evt), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .state(state), .key_sel(key_sel), .key_clr(key_clr), .irq(irq),
    .reset_req(reset_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected outputs per state: {reset_req, irq, key_clr, key_sel[1:0]}
  function automatic int exp_out(input int s);
    case (s)
      S_NONSEC:           return 1;
      S_TRUSTED, S_SECURE: return 2;
      S_SOFT:             return 4'b0_1_1_0_0 >> 0 | 12;
      S_HARD:             return 28;
      default:            return 0;
    endcase
  endfunction

  task automatic chk_state(input string req, input int exp);
    chk(req, state, exp);
    chk({req, " outputs"}, {reset_req, irq, key_clr, key_sel}, exp_out(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_state("R1 in reset", S_INIT);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_state("R1 two edges after release", S_INIT);
    @(negedge clk);
    chk_state("R1 third edge", S_CHECK);
  endtask

  task automatic sw_write(input logic [3:0] d);
    cmd_wr = 1'b1;
    cmd_data = d;
    @(negedge clk);
    cmd_wr = 1'b0;
    cmd_data = '0;
  endtask

  task automatic set_src(input int i, input logic v);
    case (i)
      0: tamper_n      = ~v;
      1: fuse_err      = v;
      2: mk_parity_err = v;
      3: scan_evt      = v;
      default: glitch_evt = v;
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boot_ext = 0; tamper_n = 1; fuse_err = 0; mk_parity_err = 0;
    scan_evt = 0; glitch_evt = 0; cmd_wr = 0; cmd_data = '0;

    // Sweep of every command value from Check (R3, R4, R7, R11)
    for (int d = 0; d < 16; d++) begin
      int e;
      do_reset();
      sw_write(4'(d));
      e = d[0] ? S_TRUSTED : S_CHECK;
      chk_state("R3 R4 R11 write in Check", e);
      if (e == S_CHECK) begin
        sw_write(4'b0001);
        chk_state("R11 trust after ignored write", S_TRUSTED);
      end
      sw_write(4'b0100);
      chk_state("R7 arm persists", d[3] ? S_HARD : S_SOFT);
    end

    // Sweep of every command value from Trusted (R4, R6, R7, R10)
    for (int d = 0; d < 16; d++) begin
      int e;
      do_reset();
      sw_write(4'b0001);
      sw_write(4'(d));
      e = d[2] ? S_SOFT : (d[1] ? S_SECURE : S_TRUSTED);
      chk_state("R4 R6 write in Trusted", e);
      if (e != S_SOFT) begin
        sw_write(4'b0100);
        e = d[3] ? S_HARD : S_SOFT;
        chk_state("R6 R7 soft fail request", e);
      end
      sw_write(4'b1001);
      sw_write(4'b0010);
      fuse_err = 1; @(negedge clk); fuse_err = 0; @(negedge clk);
      chk_state("R10 fail state held", e);
    end

    // Each source, from Trusted and Secure, armed or not (R8, R9)
    for (int i = 0; i < 5; i++) begin
      for (int sec = 0; sec < 2; sec++) begin
        for (int hf = 0; hf < 2; hf++) begin
          int st0;
          do_reset();
          if (hf != 0) sw_write(4'b1000);
          sw_write(4'b0001);
          if (sec != 0) sw_write(4'b0010);
          st0 = sec ? S_SECURE : S_TRUSTED;
          chk_state("R9 start state", st0);
          set_src(i, 1'b1);
          if (i == 0) begin
            repeat (4) @(negedge clk);
            chk_state("R8 filter latency", st0);
            @(negedge clk);
            set_src(i, 1'b0);
          end else begin
            @(negedge clk);
            set_src(i, 1'b0);
            chk_state("R9 latch edge", st0);
            @(negedge clk);
          end
          chk_state(i == 0 ? "R8 tamper violation" : "R9 source violation",
                    hf ? S_HARD : S_SOFT);
        end
      end
    end

    // Single-edge tamper pulses are filtered (R8)
    do_reset();
    sw_write(4'b0001);
    for (int k = 0; k < 3; k++) begin
      tamper_n = 0; @(negedge clk); tamper_n = 1;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk_state("R8 short pulses ignored", S_TRUSTED);

    // External boot (R2) and Non-Secure holding (R10)
    do_reset();
    boot_ext = 1; @(negedge clk); boot_ext = 0;
    chk_state("R2 external boot", S_NONSEC);
    sw_write(4'b1001);
    sw_write(4'b0110);
    glitch_evt = 1; @(negedge clk); glitch_evt = 0; @(negedge clk);
    chk_state("R10 non-secure held", S_NONSEC);

    // Violation pending with trust write on the same edge (R5)
    do_reset();
    scan_evt = 1; @(negedge clk); scan_evt = 0;
    sw_write(4'b0001);
    chk_state("R5 violation beats trust", S_NONSEC);

    // Violation latched during Init is still pending in Check (R5, R9)
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    mk_parity_err = 1; @(negedge clk); mk_parity_err = 0;
    chk_state("R9 latched through Init", S_CHECK);
    @(negedge clk);
    chk_state("R5 R9 pending from Init", S_NONSEC);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule